// File: doc/BRIEF.md
# Descriptor-framed DBI serial transmitter

This block drives a display over a 3-wire or 4-wire SPI-style serial bus. Software or a DMA engine pushes 32-bit words into an eight-entry transmit queue. The first word of each transfer is a descriptor. It sets the byte count, the command-or-data flag, the swap width and whether a completion pulse is wanted. The payload words that follow are cut into bytes, reordered if requested, and shifted out with the chosen clock polarity, clock phase and bit order.

In 4-wire mode the command/data level sits on its own pin for the whole transfer. In 3-wire mode each byte goes out as a 9-bit frame whose leading bit carries that level, and the pin is held low. Chip select stays asserted from the first bit of a transfer to the last bit of its final byte, including any wait for the next payload word. When the descriptor asks for it, a one-cycle completion pulse follows the release of chip select, and then the next descriptor is taken from the queue.

Top module: `dbi_spi_tx`

## Requirements
- R1: A descriptor word sets the transfer length and options. Bit 31 must be 1 for a transmit transfer. Bits 17:0 hold the byte count minus one. Bit 30 gives the D/C level (0 command, 1 data). Bit 29 requests a completion pulse. Bits 28:27 select the swap width (0 byte, 1 halfword, 2 word; 3 behaves as byte).
- R2: Payload bytes go out lowest byte of each word first. In the final word only as many low bytes as remain are sent. The queue word after the last payload word is taken as the next descriptor.
- R3: With swap enabled, the bytes of each payload word are reversed within units of the selected width before transmission: halfword turns 0x44332211 into 0x33441122, word turns it into 0x11223344. With swap disabled, or with byte width, words are sent unchanged.
- R4: With lsb-first selected, each data byte is shifted out bit 0 first. Otherwise bit 7 goes first.
- R5: SCLK idles at the polarity input. Each bit lasts 2*CLK_DIV system cycles, and the half-period between SCLK edges inside a byte is CLK_DIV cycles. MOSI changes at bit start and is meant to be sampled on the mid-bit edge: the leading edge when the phase input is 0, the trailing edge when it is 1.
- R6: In 4-wire mode the dc pin carries descriptor bit 30 and stays stable while cs_n is low. In 3-wire mode every byte is a 9-bit frame whose first bit is descriptor bit 30, and the dc pin stays low.
- R7: cs_n falls once per transmit transfer and stays low until the last bit of its final byte, including across payload word boundaries.
- R8: cmd_done is a one-cycle pulse. It comes exactly one cycle after cs_n rises, and only when descriptor bit 29 is set.
- R9: A descriptor with bit 31 clear is a receive request. It is removed from the queue with no bus activity and no completion pulse, and the next word is taken as a descriptor.
- R10: The queue holds FIFO_DEPTH words. A write while it is full is dropped and sets fifo_ovf. fifo_ovf stays set until ovf_clr is asserted.
- R11: fifo_full and fifo_empty reflect the fill level. fifo_thresh is high while the level is at or below the fifo_thr input.
- R12: After reset cs_n is 1, cmd_done is 0, the queue is empty, fifo_ovf is 0 and fifo_thresh is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low asynchronous reset |
| wr_en | input | 1 | queue write strobe |
| wr_data | input | 32 | descriptor or payload word |
| fifo_thr | input | CNT_W | fill-level threshold |
| ovf_clr | input | 1 | clears the overflow flag |
| cfg_cpol | input | 1 | SCLK idle level |
| cfg_cpha | input | 1 | 0: sample on leading edge, 1: on trailing edge |
| cfg_lsb_first | input | 1 | bit order of each byte |
| cfg_four_wire | input | 1 | 1: separate D/C pin, 0: 9-bit frames |
| cfg_swap | input | 1 | enables byte reordering |
| fifo_full | output | 1 | queue full |
| fifo_empty | output | 1 | queue empty |
| fifo_thresh | output | 1 | level at or below threshold |
| fifo_ovf | output | 1 | sticky overflow flag |
| sclk | output | 1 | serial clock |
| mosi | output | 1 | serial data |
| cs_n | output | 1 | active-low chip select |
| dc | output | 1 | data/command level (4-wire) |
| cmd_done | output | 1 | completion pulse |

## Verification
The queue flags are registered, so each takes its new value at the first clock edge after a write. The bench reads them at the following falling edge. Serial bits are decoded by a monitor that samples the bus on every falling edge and takes MOSI only on the edge type that the polarity and phase inputs name, so the check does not depend on the exact cycle of the first SCLK transition. The completion pulse is due exactly one cycle after cs_n rises, and the monitor checks that gap. The half-period between SCLK edges is measured against CLK_DIV. Transfers are given a fixed settling window longer than their longest duration before their results are compared.

// File: rtl/dbi_tx_pkg.sv
package dbi_tx_pkg;

    localparam int LEN_W = 18;

    typedef enum logic [1:0] {
        UNIT_BYTE = 2'd0,
        UNIT_HALF = 2'd1,
        UNIT_WORD = 2'd2
    } unit_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_SHIFT,
        ST_FINISH
    } seq_state_e;

    function automatic logic [7:0] rev8(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7-i];
        return r;
    endfunction

    function automatic logic [31:0] reorder(input logic [31:0] w, input unit_e u, input logic en);
        logic [31:0] r;
        r = w;
        if (en) begin
            case (u)
                UNIT_HALF: r = {w[23:16], w[31:24], w[7:0], w[15:8]};
                UNIT_WORD: r = {w[7:0], w[15:8], w[23:16], w[31:24]};
                default:   r = w;
            endcase
        end
        return r;
    endfunction

    // Frame is left-aligned in 9 bits; bit 8 leaves first.
    function automatic logic [8:0] make_frame(input logic [7:0] b, input logic dcb,
                                              input logic lsb, input logic four);
        logic [7:0] bits;
        bits = lsb ? rev8(b) : b;
        return four ? {bits, 1'b0} : {dcb, bits};
    endfunction

endpackage

// File: rtl/dbi_tx_fifo.sv
module dbi_tx_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 32,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    input  logic          rd_en,
    output logic [W-1:0]  rd_data,
    input  logic [CW-1:0] thr,
    input  logic          ovf_clr,
    output logic          full,
    output logic          empty,
    output logic          at_thr,
    output logic          ovf
);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           rp;
        logic [PW-1:0]           wp;
        logic [CW-1:0]           cnt;
        logic                    ovf;
    } fifo_t;

    fifo_t q, d;
    logic  push, pop;

    assign full    = (q.cnt == CW'(DEPTH));
    assign empty   = (q.cnt == '0);
    assign at_thr  = (q.cnt <= thr);
    assign ovf     = q.ovf;
    assign rd_data = q.mem[q.rp];

    always_comb begin
        d    = q;
        push = wr_en && !full;
        pop  = rd_en && !empty;
        if (push) begin
            d.mem[q.wp] = wr_data;
            d.wp        = q.wp + PW'(1);
        end
        if (pop) d.rp = q.rp + PW'(1);
        case ({push, pop})
            2'b10:   d.cnt = q.cnt + CW'(1);
            2'b01:   d.cnt = q.cnt - CW'(1);
            default: d.cnt = q.cnt;
        endcase
        if (wr_en && full)  d.ovf = 1'b1;
        else if (ovf_clr)   d.ovf = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    a_r10_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CW'(DEPTH));
    a_r10_drop_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full) |=> ovf);
    a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ovf_clr) |=> ovf);
    a_r10_full_holds_level: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en) |=> full);

endmodule

// File: rtl/dbi_tx_seq.sv
module dbi_tx_seq
    import dbi_tx_pkg::*;
#(
    parameter int CLK_DIV = 2,
    localparam int DW     = $clog2(CLK_DIV + 1),
    localparam int REM_W  = LEN_W + 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_cpol,
    input  logic        cfg_cpha,
    input  logic        cfg_lsb_first,
    input  logic        cfg_four_wire,
    input  logic        cfg_swap,
    input  logic        fifo_empty,
    input  logic [31:0] fifo_data,
    output logic        fifo_pop,
    output logic        sclk,
    output logic        mosi,
    output logic        cs_n,
    output logic        dc,
    output logic        cmd_done
);

    typedef struct packed {
        seq_state_e       state;
        logic             dc_flag;
        unit_e            unit;
        logic             irq;
        logic [REM_W-1:0] remain;
        logic [31:0]      word;
        logic [1:0]       bidx;
        logic [8:0]       shreg;
        logic [3:0]       bitcnt;
        logic             half;
        logic [DW-1:0]    divcnt;
        logic             sclk;
        logic             mosi;
        logic             cs_n;
        logic             dc_o;
        logic             done;
    } seq_t;

    seq_t        q, d;
    logic [3:0]  nbits;
    logic [31:0] sw;
    logic [7:0]  next_byte;

    assign sclk     = q.sclk;
    assign mosi     = q.mosi;
    assign cs_n     = q.cs_n;
    assign dc       = q.dc_o;
    assign cmd_done = q.done;

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        fifo_pop  = 1'b0;
        nbits     = cfg_four_wire ? 4'd8 : 4'd9;
        sw        = reorder(fifo_data, q.unit, cfg_swap);
        next_byte = 8'(q.word >> {q.bidx + 2'd1, 3'b000});
        case (q.state)
            ST_IDLE: begin
                if (!fifo_empty) begin
                    fifo_pop = 1'b1;
                    if (fifo_data[31]) begin
                        d.dc_flag = fifo_data[30];
                        d.irq     = fifo_data[29];
                        d.unit    = unit_e'(fifo_data[28:27]);
                        d.remain  = {1'b0, fifo_data[LEN_W-1:0]} + REM_W'(1);
                        d.dc_o    = cfg_four_wire & fifo_data[30];
                        d.state   = ST_FETCH;
                    end
                end
            end
            ST_FETCH: begin
                if (!fifo_empty) begin
                    fifo_pop = 1'b1;
                    d.word   = sw;
                    d.bidx   = 2'd0;
                    d.shreg  = make_frame(sw[7:0], q.dc_flag, cfg_lsb_first, cfg_four_wire);
                    d.bitcnt = 4'd0;
                    d.half   = 1'b0;
                    d.divcnt = '0;
                    d.cs_n   = 1'b0;
                    d.state  = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (q.divcnt == DW'(CLK_DIV - 1)) begin
                    d.divcnt = '0;
                    if (!q.half) begin
                        d.half = 1'b1;
                    end else begin
                        d.half = 1'b0;
                        if (q.bitcnt == nbits - 4'd1) begin
                            d.remain = q.remain - REM_W'(1);
                            d.bitcnt = 4'd0;
                            if (q.remain == REM_W'(1)) begin
                                d.cs_n  = 1'b1;
                                d.state = ST_FINISH;
                            end else if (q.bidx == 2'd3) begin
                                d.state = ST_FETCH;
                            end else begin
                                d.bidx  = q.bidx + 2'd1;
                                d.shreg = make_frame(next_byte, q.dc_flag, cfg_lsb_first, cfg_four_wire);
                            end
                        end else begin
                            d.bitcnt = q.bitcnt + 4'd1;
                            d.shreg  = {q.shreg[7:0], 1'b0};
                        end
                    end
                end else begin
                    d.divcnt = q.divcnt + DW'(1);
                end
            end
            ST_FINISH: begin
                d.done  = q.irq;
                d.state = ST_IDLE;
            end
            default: d.state = ST_IDLE;
        endcase
        d.sclk = (d.state == ST_SHIFT) ? (cfg_cpol ^ d.half ^ cfg_cpha) : cfg_cpol;
        d.mosi = d.shreg[8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.cs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> !cmd_done);
    a_r8_done_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |-> (cs_n && $past(cs_n)));
    a_r6_dc_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $past(!cs_n)) |-> $stable(dc));
    a_r10_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> !fifo_empty);
    a_r7_cs_low_while_shifting: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_SHIFT) |-> !cs_n);

endmodule

// File: rtl/dbi_spi_tx.sv
module dbi_spi_tx #(
    parameter int  FIFO_DEPTH = 8,
    parameter int  CLK_DIV    = 2,
    localparam int CNT_W      = $clog2(FIFO_DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [31:0]      wr_data,
    input  logic [CNT_W-1:0] fifo_thr,
    input  logic             ovf_clr,
    input  logic             cfg_cpol,
    input  logic             cfg_cpha,
    input  logic             cfg_lsb_first,
    input  logic             cfg_four_wire,
    input  logic             cfg_swap,
    output logic             fifo_full,
    output logic             fifo_empty,
    output logic             fifo_thresh,
    output logic             fifo_ovf,
    output logic             sclk,
    output logic             mosi,
    output logic             cs_n,
    output logic             dc,
    output logic             cmd_done
);

    logic        pop;
    logic [31:0] head;

    dbi_tx_fifo #(.DEPTH(FIFO_DEPTH), .W(32)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (pop),
        .rd_data (head),
        .thr     (fifo_thr),
        .ovf_clr (ovf_clr),
        .full    (fifo_full),
        .empty   (fifo_empty),
        .at_thr  (fifo_thresh),
        .ovf     (fifo_ovf)
    );

    dbi_tx_seq #(.CLK_DIV(CLK_DIV)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_cpol      (cfg_cpol),
        .cfg_cpha      (cfg_cpha),
        .cfg_lsb_first (cfg_lsb_first),
        .cfg_four_wire (cfg_four_wire),
        .cfg_swap      (cfg_swap),
        .fifo_empty    (fifo_empty),
        .fifo_data     (head),
        .fifo_pop      (pop),
        .sclk          (sclk),
        .mosi          (mosi),
        .cs_n          (cs_n),
        .dc            (dc),
        .cmd_done      (cmd_done)
    );

endmodule

// File: tb/dbi_spi_tx_tb_top.sv
module dbi_spi_tx_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 2;
    localparam int CW         = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [CW-1:0] fifo_thr = '0;
    logic ovf_clr = 1'b0;
    logic cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_lsb_first = 1'b0, cfg_four_wire = 1'b1, cfg_swap = 1'b0;
    logic fifo_full, fifo_empty, fifo_thresh, fifo_ovf, sclk, mosi, cs_n, dc, cmd_done;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbi_spi_tx #(.FIFO_DEPTH(8), .CLK_DIV(DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .fifo_thr(fifo_thr),
        .ovf_clr(ovf_clr), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_lsb_first(cfg_lsb_first),
        .cfg_four_wire(cfg_four_wire), .cfg_swap(cfg_swap), .fifo_full(fifo_full),
        .fifo_empty(fifo_empty), .fifo_thresh(fifo_thresh), .fifo_ovf(fifo_ovf), .sclk(sclk),
        .mosi(mosi), .cs_n(cs_n), .dc(dc), .cmd_done(cmd_done)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- bus monitor ----------------
    logic       mon_clr = 1'b0;
    int         cyc = 0;
    logic [7:0] cap_byte [0:15];
    logic       cap_dc   [0:15];
    int         cap_n, cs_falls, done_n, rise_cyc, done_cyc, last_edge, min_half, nb;
    logic [8:0] sh;
    logic       prev_sclk, prev_cs, dc_pin_bad;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (mon_clr) begin
            cap_n = 0; cs_falls = 0; done_n = 0; rise_cyc = -100; done_cyc = -200;
            last_edge = -1; min_half = 9999; nb = 0; sh = '0; dc_pin_bad = 1'b0;
        end else begin
            if (prev_cs && !cs_n) cs_falls++;
            if (!prev_cs && cs_n) rise_cyc = cyc;
            if (cmd_done) begin done_n++; done_cyc = cyc; end
            if (!cs_n && !cfg_four_wire && dc) dc_pin_bad = 1'b1;
            if (!cs_n && sclk != prev_sclk) begin
                if (last_edge >= 0 && (cyc - last_edge) < min_half) min_half = cyc - last_edge;
                last_edge = cyc;
                if (sclk == (cfg_cpha ? cfg_cpol : !cfg_cpol)) begin
                    sh = {sh[7:0], mosi};
                    nb++;
                    if (nb == (cfg_four_wire ? 8 : 9)) begin
                        if (cap_n < 16) begin
                            cap_byte[cap_n] = cfg_lsb_first ? {sh[0],sh[1],sh[2],sh[3],sh[4],sh[5],sh[6],sh[7]} : sh[7:0];
                            cap_dc[cap_n]   = cfg_four_wire ? dc : sh[8];
                        end
                        cap_n++;
                        nb = 0;
                    end
                end
            end
        end
        prev_sclk = sclk;
        prev_cs   = cs_n;
    end

    // ---------------- stimulus table ----------------
    typedef struct packed {
        logic [4:0]  cfg;   // {cpol, cpha, lsb_first, four_wire, swap}
        logic [1:0]  unit;
        logic [3:0]  n;
        logic        dcv;
        logic [63:0] exp;   // byte k of the stream in bits 8k+7:8k
    } vec_t;

    localparam vec_t [0:5] VECS = '{
        '{cfg: 5'b00010, unit: 2'd0, n: 4'd5, dcv: 1'b1, exp: 64'h0000_0055_4433_2211},
        '{cfg: 5'b11111, unit: 2'd1, n: 4'd8, dcv: 1'b0, exp: 64'h7788_5566_3344_1122},
        '{cfg: 5'b01001, unit: 2'd2, n: 4'd3, dcv: 1'b1, exp: 64'h0000_0000_0022_3344},
        '{cfg: 5'b10101, unit: 2'd0, n: 4'd6, dcv: 1'b0, exp: 64'h0000_6655_4433_2211},
        '{cfg: 5'b00011, unit: 2'd2, n: 4'd7, dcv: 1'b1, exp: 64'h0066_7788_1122_3344},
        '{cfg: 5'b00010, unit: 2'd2, n: 4'd4, dcv: 1'b0, exp: 64'h0000_0000_4433_2211}
    };

    task automatic push(input logic [31:0] w);
        wr_en   = 1'b1;
        wr_data = w;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic clear_monitor();
        mon_clr = 1'b1;
        repeat (2) @(negedge clk);
        mon_clr = 1'b0;
        @(negedge clk);
    endtask

    function automatic logic [63:0] captured(input int n);
        logic [63:0] v = '0;
        for (int k = 0; k < n && k < 8; k++) v[8*k +: 8] = cap_byte[k];
        return v;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset values while reset is held and just after release
        check(cs_n == 1'b1 && cmd_done == 1'b0, "R12 cs_n/cmd_done at reset", {cs_n, cmd_done}, 2'b10);
        check(fifo_empty && !fifo_full && !fifo_ovf && fifo_thresh, "R12 queue flags at reset",
              {fifo_empty, fifo_full, fifo_ovf, fifo_thresh}, 4'b1001);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < 6; i++) begin
            {cfg_cpol, cfg_cpha, cfg_lsb_first, cfg_four_wire, cfg_swap} = VECS[i].cfg;
            clear_monitor();
            push({1'b1, VECS[i].dcv, 1'b1, VECS[i].unit, 9'd0, 18'(VECS[i].n - 4'd1)});
            push(32'h4433_2211);
            if (VECS[i].n > 4) push(32'h8877_6655);
            repeat (400) @(negedge clk);
            check(cap_n == int'(VECS[i].n), "R1 byte count", cap_n, VECS[i].n);
            check(captured(int'(VECS[i].n)) == VECS[i].exp, "R2/R3/R4 byte stream",
                  captured(int'(VECS[i].n)), VECS[i].exp);
            begin
                bit dc_ok = 1'b1;
                for (int k = 0; k < int'(VECS[i].n); k++) if (cap_dc[k] != VECS[i].dcv) dc_ok = 1'b0;
                check(dc_ok && !dc_pin_bad, "R6 dc level", {dc_ok, dc_pin_bad}, 2'b10);
            end
            check(cs_falls == 1 && cs_n == 1'b1, "R7 single cs window", cs_falls, 1);
            check(done_n == 1 && (done_cyc - rise_cyc) == 1, "R8 done one cycle after cs release",
                  done_cyc - rise_cyc, 1);
            check(min_half == DIV, "R5 sclk half period", min_half, DIV);
            check(sclk == cfg_cpol, "R5 sclk idle level", sclk, cfg_cpol);
            check(fifo_empty, "R2 all words consumed", fifo_empty, 1);
        end

        // R9: receive descriptor discarded; R8: no done when bit 29 clear
        {cfg_cpol, cfg_cpha, cfg_lsb_first, cfg_four_wire, cfg_swap} = 5'b00010;
        clear_monitor();
        push(32'h2000_0000);
        push(32'hC000_0000);
        push(32'h0000_00A5);
        repeat (200) @(negedge clk);
        check(cap_n == 1 && cap_byte[0] == 8'hA5, "R9 receive descriptor skipped", cap_byte[0], 8'hA5);
        check(cs_falls == 1, "R9 one bus window", cs_falls, 1);
        check(done_n == 0, "R8 no done without request", done_n, 0);

        // R10/R11: overflow and threshold
        fifo_thr = 4'd8;
        push(32'hA000_00FF);
        for (int k = 0; k < 11; k++) push(32'h0101_0101 * k);
        check(fifo_ovf == 1'b1, "R10 overflow flagged", fifo_ovf, 1);
        check(fifo_full == 1'b1, "R11 full flag", fifo_full, 1);
        check(fifo_thresh == 1'b1, "R11 threshold at level", fifo_thresh, 1);
        fifo_thr = 4'd7;
        #1;
        check(fifo_thresh == 1'b0, "R11 threshold above", fifo_thresh, 0);
        repeat (50) @(negedge clk);
        check(fifo_ovf == 1'b1, "R10 overflow sticky", fifo_ovf, 1);
        ovf_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;
        check(fifo_ovf == 1'b0, "R10 overflow cleared", fifo_ovf, 0);

        // R12: reset mid-transfer
        rst_n = 1'b0;
        @(negedge clk);
        check(cs_n && !cmd_done && fifo_empty && !fifo_ovf, "R12 reset mid transfer",
              {cs_n, cmd_done, fifo_empty, fifo_ovf}, 4'b1010);
        fifo_thr = 4'd0;
        #1;
        check(fifo_thresh == 1'b1, "R12 threshold at empty", fifo_thresh, 1);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule